// File: doc/BRIEF.md
# Four-Phase AND / Carry-Branch Execute Slice

This block is the execute stage for two instructions of an 8-bit accumulator core. Each instruction cycle has four clock phases: decode, read, process and write. The first instruction combines the working register with a file register using a bitwise AND. It writes the result either to the working register or back to the file register, and it updates the negative and zero flags. The second instruction is a PC-relative branch that is taken only when the carry flag is set.

The fetch unit presents a 16-bit instruction word, the address of that instruction, the carry flag and the 4-bit bank number. It holds these values while the phase output reads decode (0). The block sends a 12-bit address to the file-register array, which answers with combinational read data. The block drives the write strobe in the write phase. For a branch, the block gives the next program counter in the write phase. When the branch is taken, the block raises busy for the whole of the following cycle so that fetch discards its prefetched word.

The working register resets to all ones. An AND into the working register therefore copies a file register into it on the first use.

Top module: `exec_slice`

## Requirements
- R1: While the synchronous active-low reset is low, the outputs take these values: phase is 0, the working register is 0xFF, both flags are 0, busy is 0, and the write strobe and PC load are 0. A reset during a busy cycle also clears busy.
- R2: After reset the phase output counts 0, 1, 2, 3 and then wraps to 0, one step per clock. The instruction inputs are sampled on the edge that leaves phase 0.
- R3: A word whose bits 15:10 are 000101 is an AND. Its result is the working register ANDed with the addressed file byte. When bit 9 is 0, the result lands in the working register at the end of phase 3, and no file write happens.
- R4: When bit 9 of an AND is 1, the write strobe is high only in phase 3, with the result on the write data and the same address. The working register keeps its value.
- R5: From phase 1 on, the file address is built from bit 8 and the low 8 bits f. When bit 8 is 0 and f is below 0x80, the address is 0x0 concatenated with f. When bit 8 is 0 and f is 0x80 or above, the address is 0xF concatenated with f. When bit 8 is 1, the address is the bank input concatenated with f.
- R6: At the end of phase 3 of an AND, N takes bit 7 of the result and Z is set when the result is zero. No other instruction changes N or Z.
- R7: A word with bits 15:8 equal to 0xE2 is the carry branch, and its low byte n is a signed offset. When the sampled carry is 1, PC load is high in phase 3. The next PC is then the instruction address + 2 + 2·n, wrapping modulo 2^16.
- R8: After a taken branch, busy is high for exactly one full four-phase cycle. Any word presented during that cycle is ignored: no file write, no PC load, and no change to W, N or Z.
- R9: A carry branch with carry 0 takes one cycle. PC load stays low, the next PC reads as the instruction address + 2, and busy stays low.
- R10: Any other opcode causes no file write, no PC load, no busy, and no change to W, N or Z.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| instr_word | input | 16 | Fetched instruction word, held during phase 0 |
| instr_pc | input | 16 | Address of the presented instruction |
| carry_in | input | 1 | Carry flag, sampled with the instruction |
| bank_sel | input | 4 | Bank number used when bit 8 is 1 |
| fr_addr | output | 12 | File-register address |
| fr_rdata | input | 8 | Combinational read data from the file array |
| fr_we | output | 1 | File-register write strobe |
| fr_wdata | output | 8 | File-register write data |
| work_reg | output | 8 | Working register |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| next_pc | output | 16 | Next program counter, valid in phase 3 |
| pc_load | output | 1 | Take next_pc as the new PC |
| busy | output | 1 | Idle cycle after a taken branch |
| phase | output | 2 | Current phase, 0 to 3 |

## Verification
The instruction is captured on the edge that leaves phase 0. The file address is therefore due one clock later, in phase 1. The write strobe, write data, PC load and next PC are due three clocks after capture, in phase 3. W, N and Z are due four clocks after capture, back in phase 0. Busy is due at that same point and lasts four further clocks. The bench drives each instruction on a falling edge in phase 0. It steps falling edge by falling edge and samples every result only in the phase at which it falls due. It compares the samples with its own model of W, the flags and a shadow of the file array.

// File: rtl/exec_pkg.sv
// Shared types for the four-phase execute slice.
// Assumes 16-bit instruction words with an 8-bit file/offset field.
package exec_pkg;

    typedef enum logic [1:0] {
        PH_DECODE  = 2'd0,
        PH_READ    = 2'd1,
        PH_PROCESS = 2'd2,
        PH_WRITE   = 2'd3
    } phase_e;

    typedef enum logic [1:0] {
        OP_NONE = 2'd0,
        OP_AND  = 2'd1,
        OP_BC   = 2'd2
    } op_e;

    localparam logic [5:0] AND_PREFIX = 6'b000101;
    localparam logic [7:0] BC_PREFIX  = 8'hE2;

    typedef struct packed {
        op_e        op;
        logic       to_file;   // bit 9: result back to the file register
        logic       banked;    // bit 8: use the bank input
        logic [7:0] lit;       // file address or branch offset
    } dec_t;

    // Classifies a word and splits out its fields.
    function automatic dec_t decode_word(input logic [15:0] iw);
        dec_t d;
        d.to_file = iw[9];
        d.banked  = iw[8];
        d.lit     = iw[7:0];
        if (iw[15:10] == AND_PREFIX)
            d.op = OP_AND;
        else if (iw[15:8] == BC_PREFIX)
            d.op = OP_BC;
        else
            d.op = OP_NONE;
        return d;
    endfunction

endpackage

// File: rtl/phase_seq.sv
// Phase sequencer: a free-running 0..3 counter plus a one-cycle idle flag.
// Assumes take_branch is only high in the write phase of a non-idle cycle.
module phase_seq (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       take_branch,
    output logic [1:0] phase,
    output logic       busy
);
    import exec_pkg::*;

    logic [1:0] ph_q;
    logic       idle_q;

    // Advance the phase and arm or clear the idle cycle at each wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q   <= 2'd0;
            idle_q <= 1'b0;
        end else begin
            ph_q <= ph_q + 2'd1;
            if (ph_q == PH_WRITE)
                idle_q <= take_branch;
        end
    end

    assign phase = ph_q;
    assign busy  = idle_q;

    assert_phase_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_WRITE) |=> (phase == PH_DECODE));
    assert_phase_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != PH_WRITE) |=> (phase == $past(phase) + 2'd1));
    assert_busy_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (phase == PH_DECODE));
    assert_busy_one_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && phase == PH_WRITE) |=> !busy);

endmodule

// File: rtl/addr_form.sv
// Banked file-address former. Assumes the access bank splits at f[7]:
// the low half maps to bank zero and the high half to the top bank.
module addr_form #(
    parameter int BANK_W = 4,
    localparam int FA_W  = BANK_W + 8
) (
    input  logic [7:0]        f,
    input  logic              banked,
    input  logic [BANK_W-1:0] bank,
    output logic [FA_W-1:0]   addr
);
    // Choose the bank part from the bank input or from the access split.
    always_comb begin
        if (banked)
            addr = {bank, f};
        else if (f[7])
            addr = {{BANK_W{1'b1}}, f};
        else
            addr = {{BANK_W{1'b0}}, f};
    end
endmodule

// File: rtl/and_unit.sv
// Logic unit: bitwise AND with negative and zero flags. Purely combinational.
module and_unit #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] res,
    output logic              neg,
    output logic              zero
);
    // Form the result and its flags.
    always_comb begin
        res  = a & b;
        neg  = res[DATA_W-1];
        zero = (res == '0);
    end
endmodule

// File: rtl/branch_target.sv
// Relative branch target: address + 2 + twice the signed 8-bit offset.
// Assumes PC_W >= 9; the sum wraps modulo 2^PC_W.
module branch_target #(
    parameter int PC_W = 16
) (
    input  logic [PC_W-1:0] pc,
    input  logic [7:0]      off,
    output logic [PC_W-1:0] target
);
    logic [PC_W-1:0] ext;

    // Sign-extend the offset, double it, and add it to the advanced address.
    always_comb begin
        ext    = {{(PC_W-8){off[7]}}, off};
        target = pc + PC_W'(2) + (ext << 1);
    end
endmodule

// File: rtl/exec_slice.sv
// Four-phase execute slice for the AND and carry-branch instructions.
// Assumes the fetch side holds its inputs stable while phase is 0, and that
// the file array returns read data combinationally from fr_addr.
module exec_slice #(
    parameter int PC_W   = 16,
    parameter int BANK_W = 4,
    parameter int DATA_W = 8,
    parameter logic [DATA_W-1:0] W_INIT = '1,
    localparam int FA_W  = BANK_W + 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [15:0]       instr_word,
    input  logic [PC_W-1:0]   instr_pc,
    input  logic              carry_in,
    input  logic [BANK_W-1:0] bank_sel,
    output logic [FA_W-1:0]   fr_addr,
    input  logic [DATA_W-1:0] fr_rdata,
    output logic              fr_we,
    output logic [DATA_W-1:0] fr_wdata,
    output logic [DATA_W-1:0] work_reg,
    output logic              flag_n,
    output logic              flag_z,
    output logic [PC_W-1:0]   next_pc,
    output logic              pc_load,
    output logic              busy
,   output logic [1:0]        phase
);
    import exec_pkg::*;

    dec_t              dec_q;
    logic [PC_W-1:0]   pc_q;
    logic              carry_q;
    logic [BANK_W-1:0] bank_q;
    logic [DATA_W-1:0] rdata_q;
    logic [DATA_W-1:0] res_q;
    logic              res_n_q;
    logic              res_z_q;
    logic [PC_W-1:0]   target_q;
    logic [DATA_W-1:0] work_q;
    logic              n_q;
    logic              z_q;

    logic [DATA_W-1:0] alu_res;
    logic              alu_n;
    logic              alu_z;
    logic [PC_W-1:0]   tgt;
    logic              taken;
    logic              in_write;

    phase_seq u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .take_branch (pc_load),
        .phase       (phase),
        .busy        (busy)
    );

    addr_form #(.BANK_W(BANK_W)) u_addr (
        .f      (dec_q.lit),
        .banked (dec_q.banked),
        .bank   (bank_q),
        .addr   (fr_addr)
    );

    and_unit #(.DATA_W(DATA_W)) u_and (
        .a    (work_q),
        .b    (rdata_q),
        .res  (alu_res),
        .neg  (alu_n),
        .zero (alu_z)
    );

    branch_target #(.PC_W(PC_W)) u_tgt (
        .pc     (pc_q),
        .off    (dec_q.lit),
        .target (tgt)
    );

    // Decode phase: latch the instruction, or a no-op during an idle cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_q   <= '{op: OP_NONE, to_file: 1'b0, banked: 1'b0, lit: 8'h00};
            pc_q    <= '0;
            carry_q <= 1'b0;
            bank_q  <= '0;
        end else if (phase == PH_DECODE) begin
            dec_q   <= busy ? '{op: OP_NONE, to_file: 1'b0, banked: 1'b0, lit: 8'h00}
                            : decode_word(instr_word);
            pc_q    <= instr_pc;
            carry_q <= carry_in;
            bank_q  <= bank_sel;
        end
    end

    // Read phase: capture the addressed file byte.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata_q <= '0;
        else if (phase == PH_READ)
            rdata_q <= fr_rdata;
    end

    // Process phase: register the AND result, its flags and the branch target.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q    <= '0;
            res_n_q  <= 1'b0;
            res_z_q  <= 1'b0;
            target_q <= '0;
        end else if (phase == PH_PROCESS) begin
            res_q    <= alu_res;
            res_n_q  <= alu_n;
            res_z_q  <= alu_z;
            target_q <= tgt;
        end
    end

    assign in_write = (phase == PH_WRITE);
    assign taken    = (dec_q.op == OP_BC) && carry_q;

    // Write phase: commit W and the flags at the end of an AND.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            work_q <= W_INIT;
            n_q    <= 1'b0;
            z_q    <= 1'b0;
        end else if (in_write && dec_q.op == OP_AND) begin
            n_q <= res_n_q;
            z_q <= res_z_q;
            if (!dec_q.to_file)
                work_q <= res_q;
        end
    end

    // Write-phase outputs to the file array and the fetch unit.
    always_comb begin
        fr_we    = in_write && (dec_q.op == OP_AND) && dec_q.to_file;
        fr_wdata = res_q;
        pc_load  = in_write && taken;
        next_pc  = taken ? target_q : pc_q + PC_W'(2);
    end

    assign work_reg = work_q;
    assign flag_n   = n_q;
    assign flag_z   = z_q;

    assert_we_in_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        fr_we |-> (phase == PH_WRITE && !busy));
    assert_load_in_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pc_load |-> (phase == PH_WRITE && !busy));
    assert_addr_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != PH_DECODE) |-> (fr_addr[7:0] == dec_q.lit));
    assert_idle_keeps_w_R8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(work_reg));
    assert_flags_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_WRITE && dec_q.op != OP_AND) |=> $stable({flag_n, flag_z}));
    assert_w_hold_on_file_R4: assert property (@(posedge clk) disable iff (!rst_n)
        fr_we |=> $stable(work_reg));

endmodule

// File: tb/test_exec_slice.sv
module test_exec_slice;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] instr_word = 16'h0000;
    logic [15:0] instr_pc = 16'h0000;
    logic        carry_in = 1'b0;
    logic [3:0]  bank_sel = 4'h0;
    logic [11:0] fr_addr;
    logic [7:0]  fr_rdata;
    logic        fr_we;
    logic [7:0]  fr_wdata;
    logic [7:0]  work_reg;
    logic        flag_n, flag_z;
    logic [15:0] next_pc;
    logic        pc_load, busy;
    logic [1:0]  phase;

    int errors = 0;
    int checks = 0;

    logic [7:0] mem     [4096];
    logic [7:0] exp_mem [4096];
    logic [7:0] exp_w;
    logic       exp_n, exp_z;

    always #2 clk = ~clk;

    exec_slice i_exec_slice (
        .clk(clk), .rst_n(rst_n), .instr_word(instr_word), .instr_pc(instr_pc),
        .carry_in(carry_in), .bank_sel(bank_sel), .fr_addr(fr_addr),
        .fr_rdata(fr_rdata), .fr_we(fr_we), .fr_wdata(fr_wdata),
        .work_reg(work_reg), .flag_n(flag_n), .flag_z(flag_z),
        .next_pc(next_pc), .pc_load(pc_load), .busy(busy), .phase(phase)
    );

    assign fr_rdata = mem[fr_addr];
    always @(posedge clk) if (fr_we) mem[fr_addr] <= fr_wdata;

    // Stimulus vectors: {instr, bank, carry, pc}
    localparam int NV = 11;
    localparam logic [36:0] VEC [NV] = '{
        {16'h1680, 4'h0, 1'b0, 16'h0010},  // AND to file, access high half: N set
        {16'h1417, 4'h0, 1'b0, 16'h0012},  // AND to W: W = 0x17
        {16'h14C2, 4'h0, 1'b0, 16'h0014},  // AND to W: W = 0x02
        {16'h17A5, 4'h3, 1'b0, 16'h0016},  // AND to file, banked: Z set
        {16'h167F, 4'h9, 1'b0, 16'h0018},  // AND to file, access low edge 0x7F
        {16'hE205, 4'h0, 1'b0, 16'h0100},  // branch, carry clear
        {16'hE205, 4'h0, 1'b1, 16'h0100},  // branch forward
        {16'hE280, 4'h0, 1'b1, 16'h0200},  // branch most negative
        {16'hE2FF, 4'h0, 1'b1, 16'h0000},  // branch -1 to self
        {16'hE27F, 4'h0, 1'b1, 16'hFFFE},  // branch wraps
        {16'hE305, 4'h2, 1'b1, 16'h0300}   // unknown opcode
    };

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [11:0] model_addr(input logic [7:0] f, input bit banked,
                                               input logic [3:0] bk);
        if (banked) return {bk, f};
        return f[7] ? {4'hF, f} : {4'h0, f};
    endfunction

    // Runs one instruction from phase 0 and checks every result at its due phase.
    task automatic run_instr(input logic [15:0] iw, input logic [3:0] bk,
                             input bit c, input logic [15:0] pc);
        bit          is_and, is_bc, tk;
        logic [11:0] ea;
        logic [7:0]  res;
        logic [15:0] tgt;
        is_and = (iw[15:10] == 6'b000101);
        is_bc  = (iw[15:8] == 8'hE2);
        tk     = is_bc && c;
        ea     = model_addr(iw[7:0], iw[8], bk);
        res    = exp_w & exp_mem[ea];
        tgt    = pc + 16'd2 + {{7{iw[7]}}, iw[7:0], 1'b0};
        check(phase == 2'd0, "R2", "phase at issue", 32'(phase), 0);
        instr_word = iw; bank_sel = bk; carry_in = c; instr_pc = pc;
        @(negedge clk);
        check(phase == 2'd1, "R2", "phase 1", 32'(phase), 1);
        if (is_and) check(fr_addr == ea, "R5", "file address", 32'(fr_addr), 32'(ea));
        instr_word = 16'hFFFF;
        @(negedge clk);
        check(phase == 2'd2, "R2", "phase 2", 32'(phase), 2);
        @(negedge clk);
        check(fr_we == (is_and && iw[9]), "R4", "write strobe", 32'(fr_we), 32'(is_and && iw[9]));
        if (is_and && iw[9]) begin
            check(fr_wdata == res, "R4", "write data", 32'(fr_wdata), 32'(res));
            exp_mem[ea] = res;
        end
        check(pc_load == tk, tk ? "R7" : "R9", "pc load", 32'(pc_load), 32'(tk));
        if (is_bc) check(next_pc == (tk ? tgt : pc + 16'd2), tk ? "R7" : "R9",
                         "next pc", 32'(next_pc), 32'(tk ? tgt : pc + 16'd2));
        if (is_and) begin
            if (!iw[9]) exp_w = res;
            exp_n = res[7];
            exp_z = (res == 8'h00);
        end
        @(negedge clk);
        check(work_reg == exp_w, is_and ? "R3" : "R10", "W", 32'(work_reg), 32'(exp_w));
        check({flag_n, flag_z} == {exp_n, exp_z}, is_and ? "R6" : "R10", "N,Z",
              32'({flag_n, flag_z}), 32'({exp_n, exp_z}));
        check(mem[ea] == exp_mem[ea], is_and ? "R3" : "R10", "file byte",
              32'(mem[ea]), 32'(exp_mem[ea]));
        check(busy == tk, tk ? "R8" : "R9", "busy after", 32'(busy), 32'(tk));
        if (tk) begin
            instr_word = 16'h17FF; bank_sel = 4'h3; carry_in = 1'b1;
            for (int k = 0; k < 4; k++) begin
                check(busy && !fr_we && !pc_load, "R8", "idle cycle quiet",
                      32'({busy, fr_we, pc_load}), 32'b100);
                @(negedge clk);
            end
            check(!busy, "R8", "busy ends", 32'(busy), 0);
            check(work_reg == exp_w && mem[12'h3FF] == exp_mem[12'h3FF], "R8",
                  "ignored word", 32'(work_reg), 32'(exp_w));
        end
    endtask

    initial begin
        #(200000 * 4);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < 4096; i++) begin
            mem[i] = 8'(i * 29 + 7);
        end
        mem[12'hF80] = 8'h80; mem[12'h017] = 8'h17; mem[12'hFC2] = 8'hC2;
        mem[12'h3A5] = 8'hF0; mem[12'h07F] = 8'h3C; mem[12'h3FF] = 8'hFF;
        for (int i = 0; i < 4096; i++) exp_mem[i] = mem[i];
        exp_w = 8'hFF; exp_n = 1'b0; exp_z = 1'b0;

        repeat (3) @(negedge clk);
        // R1: reset state
        check(phase == 0 && !busy && !fr_we && !pc_load, "R1", "reset controls",
              32'({phase, busy, fr_we, pc_load}), 0);
        check(work_reg == 8'hFF && !flag_n && !flag_z, "R1", "reset W/flags",
              32'({work_reg, flag_n, flag_z}), 32'h3FC);
        rst_n = 1'b1;

        for (int v = 0; v < NV; v++) begin
            run_instr(VEC[v][36:21], VEC[v][20:17], VEC[v][16], VEC[v][15:0]);
        end

        // R1: reset taken during the idle cycle clears busy and restores W
        run_instr(16'h1417, 4'h0, 1'b0, 16'h0400);
        instr_word = 16'hE210; carry_in = 1'b1; instr_pc = 16'h0500;
        repeat (4) @(negedge clk);
        check(busy, "R8", "busy before reset", 32'(busy), 1);
        rst_n = 1'b0;
        @(negedge clk);
        check(!busy && phase == 0 && work_reg == 8'hFF && !flag_n && !flag_z,
              "R1", "reset in idle", 32'({busy, phase, work_reg}), 32'h0FF);
        rst_n = 1'b1;
        exp_w = 8'hFF; exp_n = 1'b0; exp_z = 1'b0;
        run_instr(16'h1417, 4'h0, 1'b0, 16'h0600);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule